// File: doc/BRIEF.md
# Privilege-Gated Counter CSR Unit

This block is the machine-level control and status register unit of a small 64-bit core. It holds the status, ISA-description and identification registers, the two masks that grant counter access to lower privilege levels, and the current privilege level. It also runs a free-running cycle counter and a retired-instruction counter. The pipeline reaches it through a single-cycle register port. The port carries an address, a read strobe, a write strobe and write data. Read data and an illegal-access flag come back combinationally in the same cycle. The port has no back-pressure: every access completes in the cycle it is presented, so no valid/ready handshake is needed.

A counter read is gated by the current privilege level. Machine mode always sees the counter. Supervisor mode is governed by the machine-level mask. User mode is governed only by the supervisor-level mask. A gated-off counter reads as zero and raises no illegal-access flag. All counter addresses are read-only, and writes to them are dropped.

The interrupt-pending and interrupt-enable registers are not stored here. Their reads and writes are routed to an external interrupt-controller port. Trap entry and return drive the privilege level through a load strobe.

Top module: `csr_unit`

## Requirements
- R1: After reset the privilege level is machine (3). The ISA register (0x301) reads 0x800000000014112D. The status register (0x300) reads 0x0000000A00002000, which is 2 in bits 33:32, 2 in bits 35:34 and 1 in bits 14:13. Both counter masks (0x306 machine, 0x106 supervisor) read 0x7. The ID registers 0xF11, 0xF12 and 0xF13 read 0.
- R2: The 64-bit cycle counter advances by one on every clock edge out of reset. It reads 1 in the first cycle after reset is released.
- R3: The 64-bit retired-instruction counter advances by one on each clock edge where `retire` is high. It holds otherwise.
- R4: Counter addresses are 0xC00 + i for i = 0..31. Index 0 returns the cycle count, index 1 returns `time_in`, index 2 returns the retired count, and indices 3..31 return the cycle count.
- R5: Privilege encoding is 0 user, 1 supervisor, 3 machine. Machine mode may read every counter. Supervisor mode may read counter i only when bit i of the machine mask is set. User mode may read counter i only when bit i of the supervisor mask is set, whatever the machine mask holds.
- R6: A read of a counter that is not permitted returns 0 and leaves `csr_illegal` low.
- R7: A write to any counter address changes no register and does not alter the counters.
- R8: Accesses to 0x344 (pending) and 0x304 (enable) are forwarded. A write pulses `irq_pend_wr` or `irq_en_wr` with `irq_wdata` equal to `csr_wdata`. A read returns `irq_pend_rd` or `irq_en_rd`. The write pulses stay low for every other address.
- R9: A read or write to an address not listed in R1, R4 or R8 raises `csr_illegal` in that cycle and reads 0. A write to such an address changes no state.
- R10: Writes to the status and ISA registers store all 64 bits. Writes to the counter masks store bits 31:0, and the upper bits read 0. Writes to the ID registers are ignored.
- R11: `priv_load` copies `priv_next` into the privilege level on the next edge. The reserved encoding 2 is ignored and the level is kept.
- R12: `csr_rdata` is 0 whenever `csr_rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_rd_en | input | 1 | Read strobe |
| csr_wr_en | input | 1 | Write strobe |
| csr_wdata | input | 64 | Write data |
| csr_rdata | output | 64 | Read data, same cycle |
| csr_illegal | output | 1 | Access to an unimplemented address |
| priv_load | input | 1 | Load a new privilege level |
| priv_next | input | 2 | Privilege level to load |
| priv_cur | output | 2 | Current privilege level |
| retire | input | 1 | One instruction retired this cycle |
| time_in | input | 64 | External real-time value |
| irq_pend_wr | output | 1 | Write strobe to the pending register |
| irq_en_wr | output | 1 | Write strobe to the enable register |
| irq_wdata | output | 64 | Data for the forwarded write |
| irq_pend_rd | input | 64 | Pending register value from the controller |
| irq_en_rd | input | 64 | Enable register value from the controller |

## Verification
The hardest case to reach is user-mode gating. There, a wrong choice of mask would only show if the two masks differ bit by bit while the core runs below machine level. The stimulus first loads distinct masks from machine mode. It then drops to supervisor and then user mode through `priv_load` and sweeps all 32 counter addresses in each mode. A reference model in the bench predicts every counter value and every gated zero on every clock.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;
  parameter int XLEN    = 64;
  parameter int NUM_CNT = 32;
  localparam int IDX_W  = $clog2(NUM_CNT);

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [3:0] {
    CL_NONE, CL_CNT, CL_STATUS, CL_ISA, CL_MMASK,
    CL_SMASK, CL_IE, CL_IP, CL_ID
  } cls_e;

  localparam logic [11:0] AD_STATUS = 12'h300;
  localparam logic [11:0] AD_ISA    = 12'h301;
  localparam logic [11:0] AD_IE     = 12'h304;
  localparam logic [11:0] AD_MMASK  = 12'h306;
  localparam logic [11:0] AD_SMASK  = 12'h106;
  localparam logic [11:0] AD_IP     = 12'h344;
  localparam logic [11:0] AD_ID0    = 12'hF11;
  localparam logic [11:0] AD_ID1    = 12'hF12;
  localparam logic [11:0] AD_ID2    = 12'hF13;
  localparam logic [11:0] AD_CNT    = 12'hC00;

  localparam int IDX_TIME    = 1;
  localparam int IDX_INSTRET = 2;

  function automatic cls_e classify(input logic [11:0] a);
    cls_e c;
    if (a[11:IDX_W] == AD_CNT[11:IDX_W]) c = CL_CNT;
    else begin
      case (a)
        AD_STATUS:              c = CL_STATUS;
        AD_ISA:                 c = CL_ISA;
        AD_IE:                  c = CL_IE;
        AD_MMASK:               c = CL_MMASK;
        AD_SMASK:               c = CL_SMASK;
        AD_IP:                  c = CL_IP;
        AD_ID0, AD_ID1, AD_ID2: c = CL_ID;
        default:                c = CL_NONE;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/csr_counters.sv
module csr_counters
  import csr_unit_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         retire,
  output logic [W-1:0] cycle_q,
  output logic [W-1:0] instret_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycle_q   <= '0;
      instret_q <= '0;
    end else begin
      cycle_q <= cycle_q + W'(1);
      if (retire) instret_q <= instret_q + W'(1);
    end
  end

  assert_cycle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> cycle_q == $past(cycle_q) + W'(1));

  assert_instret_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(retire)) |-> instret_q == $past(instret_q) + W'(1));

  assert_instret_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(retire)) |-> $stable(instret_q));
endmodule

// File: rtl/csr_state.sv
module csr_state
  import csr_unit_pkg::*;
#(
  parameter int          W       = XLEN,
  parameter int          NCNT    = NUM_CNT,
  parameter logic [25:0] EXT_SET = 26'h014112D
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cls_e            cls,
  input  logic            wr_en,
  input  logic [W-1:0]    wdata,
  input  logic            priv_load,
  input  logic [1:0]      priv_next,
  output logic [W-1:0]    status_q,
  output logic [W-1:0]    isa_q,
  output logic [NCNT-1:0] mmask_q,
  output logic [NCNT-1:0] smask_q,
  output priv_e           priv_q
);
  localparam logic [W-1:0] ISA_RST =
    (W'(2) << (W - 2)) | W'(EXT_SET);
  localparam logic [W-1:0] STATUS_RST =
    (W'(2) << 32) | (W'(2) << 34) | (W'(1) << 13);
  localparam logic [NCNT-1:0] MASK_RST = NCNT'(7);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      isa_q    <= ISA_RST;
      mmask_q  <= MASK_RST;
      smask_q  <= MASK_RST;
      priv_q   <= PRIV_M;
    end else begin
      if (wr_en) begin
        case (cls)
          CL_STATUS: status_q <= wdata;
          CL_ISA:    isa_q    <= wdata;
          CL_MMASK:  mmask_q  <= wdata[NCNT-1:0];
          CL_SMASK:  smask_q  <= wdata[NCNT-1:0];
          default: ;
        endcase
      end
      if (priv_load && priv_e'(priv_next) != PRIV_RSV)
        priv_q <= priv_e'(priv_next);
    end
  end

  assert_cnt_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cls == CL_CNT) |=>
      ($stable(status_q) && $stable(isa_q) && $stable(mmask_q) && $stable(smask_q)));

  assert_bad_addr_no_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cls == CL_NONE) |=>
      ($stable(status_q) && $stable(isa_q) && $stable(mmask_q) && $stable(smask_q)));

  assert_priv_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    priv_q != PRIV_RSV);
endmodule

// File: rtl/csr_readmux.sv
module csr_readmux
  import csr_unit_pkg::*;
#(
  parameter int W    = XLEN,
  parameter int NCNT = NUM_CNT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cls_e            cls,
  input  logic [IDX_W-1:0] idx,
  input  logic            rd_en,
  input  logic            wr_en,
  input  priv_e           priv,
  input  logic [NCNT-1:0] mmask,
  input  logic [NCNT-1:0] smask,
  input  logic [W-1:0]    cycle,
  input  logic [W-1:0]    instret,
  input  logic [W-1:0]    time_in,
  input  logic [W-1:0]    status,
  input  logic [W-1:0]    isa,
  input  logic [W-1:0]    pend_rd,
  input  logic [W-1:0]    en_rd,
  output logic [W-1:0]    rdata,
  output logic            illegal
);
  logic [W-1:0] src [NCNT];
  logic         granted;
  logic [W-1:0] raw;

  for (genvar g = 0; g < NCNT; g++) begin : g_src
    if (g == IDX_TIME) begin : g_time
      assign src[g] = time_in;
    end else if (g == IDX_INSTRET) begin : g_ret
      assign src[g] = instret;
    end else begin : g_cyc
      assign src[g] = cycle;
    end
  end

  always_comb begin
    case (priv)
      PRIV_M:  granted = 1'b1;
      PRIV_S:  granted = mmask[idx];
      PRIV_U:  granted = smask[idx];
      default: granted = 1'b0;
    endcase
  end

  always_comb begin
    case (cls)
      CL_CNT:    raw = granted ? src[idx] : '0;
      CL_STATUS: raw = status;
      CL_ISA:    raw = isa;
      CL_MMASK:  raw = W'(mmask);
      CL_SMASK:  raw = W'(smask);
      CL_IE:     raw = en_rd;
      CL_IP:     raw = pend_rd;
      default:   raw = '0;
    endcase
  end

  assign rdata   = rd_en ? raw : '0;
  assign illegal = (rd_en | wr_en) && cls == CL_NONE;

  assert_bad_addr_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> rdata == '0);

  assert_idle_port_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> rdata == '0);

  assert_user_mask_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cls == CL_CNT && priv == PRIV_U && !smask[idx]) |-> rdata == '0);

  assert_gated_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CL_CNT) |-> !illegal);
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_unit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] csr_addr,
  input  logic        csr_rd_en,
  input  logic        csr_wr_en,
  input  logic [63:0] csr_wdata,
  output logic [63:0] csr_rdata,
  output logic        csr_illegal,
  input  logic        priv_load,
  input  logic [1:0]  priv_next,
  output logic [1:0]  priv_cur,
  input  logic        retire,
  input  logic [63:0] time_in,
  output logic        irq_pend_wr,
  output logic        irq_en_wr,
  output logic [63:0] irq_wdata,
  input  logic [63:0] irq_pend_rd,
  input  logic [63:0] irq_en_rd
);
  localparam int W = XLEN;

  cls_e               cls;
  logic [W-1:0]       cycle_q, instret_q, status_q, isa_q;
  logic [NUM_CNT-1:0] mmask_q, smask_q;
  priv_e              priv_q;

  assign cls = classify(csr_addr);

  csr_counters #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .retire(retire),
    .cycle_q(cycle_q), .instret_q(instret_q)
  );

  csr_state #(.W(W), .NCNT(NUM_CNT)) u_state (
    .clk(clk), .rst_n(rst_n), .cls(cls), .wr_en(csr_wr_en), .wdata(csr_wdata),
    .priv_load(priv_load), .priv_next(priv_next),
    .status_q(status_q), .isa_q(isa_q), .mmask_q(mmask_q), .smask_q(smask_q),
    .priv_q(priv_q)
  );

  csr_readmux #(.W(W), .NCNT(NUM_CNT)) u_rd (
    .clk(clk), .rst_n(rst_n), .cls(cls), .idx(csr_addr[IDX_W-1:0]),
    .rd_en(csr_rd_en), .wr_en(csr_wr_en), .priv(priv_q),
    .mmask(mmask_q), .smask(smask_q), .cycle(cycle_q), .instret(instret_q),
    .time_in(time_in), .status(status_q), .isa(isa_q),
    .pend_rd(irq_pend_rd), .en_rd(irq_en_rd),
    .rdata(csr_rdata), .illegal(csr_illegal)
  );

  assign priv_cur    = priv_q;
  assign irq_pend_wr = csr_wr_en && cls == CL_IP;
  assign irq_en_wr   = csr_wr_en && cls == CL_IE;
  assign irq_wdata   = csr_wdata;

  assert_fwd_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_pend_wr && irq_en_wr));

  assert_fwd_only_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend_wr || irq_en_wr) |-> csr_wr_en);
endmodule

// File: tb/tb_csr_unit.sv
`timescale 1ns/1ps
module tb_csr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic        csr_rd_en = 1'b0, csr_wr_en = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        csr_illegal;
  logic        priv_load = 1'b0;
  logic [1:0]  priv_next = '0;
  logic [1:0]  priv_cur;
  logic        retire = 1'b0;
  logic [63:0] time_in = 64'h0000_1234_0000_0001;
  logic        irq_pend_wr, irq_en_wr;
  logic [63:0] irq_wdata;
  logic [63:0] irq_pend_rd = 64'h0000_0000_0000_0888;
  logic [63:0] irq_en_rd   = 64'h0000_0000_0000_0AAA;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  csr_unit dut (.*);

  // reference model state
  longint unsigned m_cycle, m_instret;
  logic [63:0] m_status, m_isa, m_mmask, m_smask;
  logic [1:0]  m_priv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cycle = 0; m_instret = 0;
      m_status = 64'h0000_000A_0000_2000;
      m_isa    = 64'h8000_0000_0014_112D;
      m_mmask  = 64'h7; m_smask = 64'h7;
      m_priv   = 2'd3;
    end else begin
      m_cycle++;
      if (retire) m_instret++;
      if (priv_load && priv_next != 2'd2) m_priv = priv_next;
      if (csr_wr_en) begin
        case (csr_addr)
          12'h300: m_status = csr_wdata;
          12'h301: m_isa    = csr_wdata;
          12'h306: m_mmask  = {32'h0, csr_wdata[31:0]};
          12'h106: m_smask  = {32'h0, csr_wdata[31:0]};
          default: ;
        endcase
      end
    end
  end

  function automatic bit is_cnt(logic [11:0] a);
    return a[11:5] == 7'h60;
  endfunction

  function automatic bit known(logic [11:0] a);
    if (is_cnt(a)) return 1;
    case (a)
      12'h300, 12'h301, 12'h304, 12'h306, 12'h106, 12'h344,
      12'hF11, 12'hF12, 12'hF13: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] exp_rd(logic [11:0] a);
    if (is_cnt(a)) begin
      int i = int'(a[4:0]);
      bit ok = (m_priv == 2'd3) ? 1'b1 :
               (m_priv == 2'd1) ? m_mmask[i] :
               (m_priv == 2'd0) ? m_smask[i] : 1'b0;
      if (!ok) return 64'h0;
      if (i == 1) return time_in;
      if (i == 2) return m_instret;
      return m_cycle;
    end
    case (a)
      12'h300: return m_status;
      12'h301: return m_isa;
      12'h306: return m_mmask;
      12'h106: return m_smask;
      12'h304: return irq_en_rd;
      12'h344: return irq_pend_rd;
      default: return 64'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a);
    if (is_cnt(a)) return (m_priv == 2'd3) ? "R4" : "R5/R6";
    if (a == 12'h304 || a == 12'h344) return "R8";
    if (!known(a)) return "R9";
    return "R10";
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(csr_rd_en ? tag_of(csr_addr) : "R12", csr_rdata,
          csr_rd_en ? exp_rd(csr_addr) : 64'h0);
      chk("R9 flag", {63'h0, csr_illegal},
          {63'h0, (csr_rd_en | csr_wr_en) && !known(csr_addr)});
      chk("R11 priv", {62'h0, priv_cur}, {62'h0, m_priv});
      chk("R8 pend_wr", {63'h0, irq_pend_wr}, {63'h0, csr_wr_en && csr_addr == 12'h344});
      chk("R8 en_wr", {63'h0, irq_en_wr}, {63'h0, csr_wr_en && csr_addr == 12'h304});
      if (csr_wr_en) chk("R8 wdata", irq_wdata, csr_wdata);
    end
  end

  task automatic acc(logic [11:0] a, bit rd, bit wr, logic [63:0] d);
    @(posedge clk); #1;
    csr_addr = a; csr_rd_en = rd; csr_wr_en = wr; csr_wdata = d;
    @(posedge clk); #1;
    csr_rd_en = 0; csr_wr_en = 0;
  endtask

  task automatic rd_now(logic [11:0] a, string tag, logic [63:0] exp);
    @(posedge clk); #1;
    csr_addr = a; csr_rd_en = 1;
    @(negedge clk);
    chk(tag, csr_rdata, exp);
    @(posedge clk); #1;
    csr_rd_en = 0;
  endtask

  task automatic set_priv(logic [1:0] p);
    @(posedge clk); #1;
    priv_load = 1; priv_next = p;
    @(posedge clk); #1;
    priv_load = 0;
  endtask

  task automatic sweep();
    for (int i = 0; i < 32; i++) acc(12'hC00 + 12'(i), 1, 0, 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 priv in reset", {62'h0, priv_cur}, 64'h3);
    #1 rst_n = 1;
    // R1 reset values
    rd_now(12'h301, "R1 isa", 64'h8000_0000_0014_112D);
    rd_now(12'h300, "R1 status", 64'h0000_000A_0000_2000);
    rd_now(12'h306, "R1 mmask", 64'h7);
    rd_now(12'h106, "R1 smask", 64'h7);
    rd_now(12'hF11, "R1 id0", 64'h0);
    rd_now(12'hF12, "R1 id1", 64'h0);
    rd_now(12'hF13, "R1 id2", 64'h0);
    // R2 R3 R4 counters in machine mode
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1 retire = 1;
      @(posedge clk); #1 retire = 0;
    end
    rd_now(12'hC02, "R3 instret", 64'd5);
    sweep();
    // R7 writes to counters dropped
    acc(12'hC00, 0, 1, 64'hFFFF);
    acc(12'hC02, 0, 1, 64'h0);
    acc(12'hC1F, 1, 1, 64'h55);
    rd_now(12'hC02, "R7 instret kept", 64'd5);
    // R10 writable registers, ID write ignored
    acc(12'h300, 0, 1, 64'hDEAD_BEEF_0123_4567);
    acc(12'h301, 1, 1, 64'h8000_0000_0000_1105);
    acc(12'h306, 0, 1, 64'hFFFF_0000_0000_0005);
    rd_now(12'h306, "R10 mask upper zero", 64'h5);
    acc(12'h106, 0, 1, 64'h0000_0000_8000_000A);
    acc(12'hF11, 0, 1, 64'h1);
    rd_now(12'hF11, "R10 id ignored", 64'h0);
    // R9 unknown address
    acc(12'h7FF, 1, 0, 64'h0);
    acc(12'h305, 0, 1, 64'h99);
    rd_now(12'h300, "R9 no state change", 64'hDEAD_BEEF_0123_4567);
    // R5 R6 supervisor: machine mask 0x5
    set_priv(2'd1);
    sweep();
    rd_now(12'hC01, "R6 S time gated", 64'h0);
    // R11 reserved ignored
    set_priv(2'd2);
    // R5 user: supervisor mask 0x8000000A
    set_priv(2'd0);
    sweep();
    rd_now(12'hC00, "R5 U cycle gated", 64'h0);
    rd_now(12'hC01, "R5 U time allowed", time_in);
    time_in = 64'hCAFE_0000_0000_0042;
    rd_now(12'hC01, "R4 time follows input", 64'hCAFE_0000_0000_0042);
    rd_now(12'hC02, "R5 U instret gated", 64'h0);
    // R8 forwarding
    acc(12'h344, 1, 1, 64'h0000_0000_0000_0080);
    acc(12'h304, 1, 1, 64'h0000_0000_0000_0808);
    irq_pend_rd = 64'h1;
    rd_now(12'h344, "R8 pend read", 64'h1);
    set_priv(2'd3);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1 retire = 1;
    end
    @(posedge clk); #1 retire = 0;
    rd_now(12'hC02, "R3 instret after burst", 64'd8);
    sweep();
    repeat (2) @(posedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule